// File: doc/BRIEF.md
# APB Seconds Counter with Alarm

This peripheral keeps a 32-bit count of elapsed seconds. The count advances from an internal prescaler that divides the bus clock by `CLK_HZ`. Software reaches it through an APB-style slave port. Software can preset the count, program an alarm value and gate a single alarm interrupt onto a level-sensitive output. The count wraps modulo 2^32, and the alarm comparison follows it through the wrap.

The alarm is edge-like. The raw status bit is set whenever the count or the alarm value changes so that the two become equal. This covers a one-second increment, a load write and an alarm write. The bit stays set until software writes the clear register. A small block of read-only identification bytes sits at the top of the 4 KiB window. The control register is a placeholder: it always reads as enabled and ignores writes.

Top module: `apb_rtc_alarm`

## Requirements
- R1: A synchronous active-low reset sets the count, alarm value, load readback, mask bit and raw status to zero, and the interrupt output is low.
- R2: Without a load write, the count (read at offset 0x00) rises by exactly one every `CLK_HZ` clocks and wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x08 replaces the count with the written data and restarts the prescaler, so the next increment comes `CLK_HZ` clocks after that write. A read of 0x08 returns the last written data, not the live count.
- R4: The alarm value is written and read at offset 0x04. An increment that makes the count equal the alarm value sets raw status (bit 0 at offset 0x14), including an increment through the wrap.
- R5: A load write or an alarm write that leaves count and alarm value equal sets raw status in the same cycle the write takes effect.
- R6: Only bit 0 of a write to offset 0x10 is kept as the mask, and that bit reads back at 0x10. The interrupt output and bit 0 of offset 0x18 both equal raw status AND mask.
- R7: Any write to offset 0x1C clears raw status, whatever the data. If an alarm hit falls in the same cycle, raw status ends up set.
- R8: Offset 0x0C always reads as 1, and writes to it change nothing.
- R9: The eight word offsets 0xFE0, 0xFE4, and so on up to 0xFFC return, in that address order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in bits 7:0, with zeros above.
- R10: Reads of 0x1C and of unmapped offsets return zero. Writes to 0x00, 0x14, 0x18 or unmapped offsets leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and prescaler clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase qualifier |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for read |
| pready | output | 1 | Always high; no wait states |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
Two functions can coincide in one cycle. The first pair is a prescaler increment that reaches the alarm value and a software write to the clear register. The second pair is an increment and a load write. The bench provokes the first pair by loading a count one below the alarm value, waiting a counted number of cycles, and issuing the clear so that its access phase ends on exactly the increment edge. It then expects raw status still set and the count advanced. Load-versus-increment timing is judged by reading the count one cycle before and one cycle after the edge that lies `CLK_HZ` clocks past the load.

// File: rtl/rtc_pkg.sv
// Package: shared constants, types and the identification byte table
// for the APB seconds counter. Assumes a 4 KiB word-aligned window.
package rtc_pkg;

    localparam int REG_AW = 12;
    localparam int DATA_W = 32;

    // Word indices (byte offset >> 2) of the mapped registers.
    localparam logic [9:0] W_COUNT  = 10'h000;
    localparam logic [9:0] W_ALARM  = 10'h001;
    localparam logic [9:0] W_LOAD   = 10'h002;
    localparam logic [9:0] W_CTRL   = 10'h003;
    localparam logic [9:0] W_MASK   = 10'h004;
    localparam logic [9:0] W_RAW    = 10'h005;
    localparam logic [9:0] W_MASKED = 10'h006;
    localparam logic [9:0] W_CLEAR  = 10'h007;
    // Identification bytes occupy the last eight words.
    localparam logic [6:0] W_ID_HI  = 7'h7F;

    typedef enum logic [3:0] {
        RS_COUNT,
        RS_ALARM,
        RS_LOAD,
        RS_CTRL,
        RS_MASK,
        RS_RAW,
        RS_MASKED,
        RS_ID,
        RS_ZERO
    } rd_sel_e;

    typedef struct packed {
        logic load;
        logic alarm;
        logic mask;
        logic clear;
    } wr_strb_t;

    // Identification byte for a word index within the ID block.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h31;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_apb_decode.sv
// Module: rtc_apb_decode
// Turns an APB access into one write strobe per writable register and a
// read selector. Writes take effect only in the access phase; the read
// selector is combinational on the address. Unaligned addresses are treated
// as unmapped. Assumes a single outstanding access.
module rtc_apb_decode
    import rtc_pkg::*;
(
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [REG_AW-1:0] paddr,
    output wr_strb_t          wr,
    output rd_sel_e           rd_sel,
    output logic [2:0]        id_idx
);

    logic [9:0] word;
    logic       aligned;
    logic       wr_go;

    assign word    = paddr[REG_AW-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_go   = psel && penable && pwrite && aligned;
    assign id_idx  = word[2:0];

    // Write strobes: one per register with side effects on write.
    always_comb begin
        wr       = '0;
        wr.load  = wr_go && (word == W_LOAD);
        wr.alarm = wr_go && (word == W_ALARM);
        wr.mask  = wr_go && (word == W_MASK);
        wr.clear = wr_go && (word == W_CLEAR);
    end

    // Read selector: maps the word index to a readback source.
    always_comb begin
        rd_sel = RS_ZERO;
        if (aligned) begin
            if (word[9:3] == W_ID_HI) begin
                rd_sel = RS_ID;
            end else begin
                case (word)
                    W_COUNT:  rd_sel = RS_COUNT;
                    W_ALARM:  rd_sel = RS_ALARM;
                    W_LOAD:   rd_sel = RS_LOAD;
                    W_CTRL:   rd_sel = RS_CTRL;
                    W_MASK:   rd_sel = RS_MASK;
                    W_RAW:    rd_sel = RS_RAW;
                    W_MASKED: rd_sel = RS_MASKED;
                    default:  rd_sel = RS_ZERO;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Divides the clock to a one-cycle tick every CLK_HZ clocks. A restart
// pulse returns the divider to zero, so the next tick comes CLK_HZ clocks
// after the restart edge. Assumes CLK_HZ >= 1.
module rtc_prescaler #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int            CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

    logic [CNT_W-1:0] div_q;

    assign tick = (div_q == LAST);

    // Divider: counts 0..CLK_HZ-1, restarts on request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_counter_alarm.sv
// Module: rtc_counter_alarm
// Holds the seconds count, alarm value, load readback, mask and raw status.
// The alarm is evaluated on the next-state count and alarm whenever either
// changes (increment, load write, alarm write), so equality caused by a
// write is caught in the same cycle. A hit wins over a clear.
module rtc_counter_alarm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  wr_strb_t          wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] alarm_q,
    output logic [DATA_W-1:0] load_q,
    output logic              mask_q,
    output logic              status_q
);

    logic [DATA_W-1:0] count_d;
    logic [DATA_W-1:0] alarm_d;
    logic              changed;
    logic              hit;

    // Next count: a load overrides any increment in the same cycle.
    always_comb begin
        if (wr.load) begin
            count_d = wdata;
        end else if (tick) begin
            count_d = count_q + 1'b1;
        end else begin
            count_d = count_q;
        end
    end

    assign alarm_d = wr.alarm ? wdata : alarm_q;
    assign changed = wr.load || wr.alarm || tick;
    assign hit     = changed && (count_d == alarm_d);

    // Count, alarm and load readback registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            alarm_q <= '0;
            load_q  <= '0;
        end else begin
            count_q <= count_d;
            alarm_q <= alarm_d;
            if (wr.load) begin
                load_q <= wdata;
            end
        end
    end

    // Mask bit: only data bit 0 is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr.mask) begin
            mask_q <= wdata[0];
        end
    end

    // Raw status: set on hit, cleared by any clear write, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (wr.clear) begin
            status_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_read_mux.sv
// Module: rtc_read_mux
// Combinational readback multiplexer. The control register reads as a
// constant 1; unmapped and write-only locations read as zero.
module rtc_read_mux
    import rtc_pkg::*;
(
    input  rd_sel_e           rd_sel,
    input  logic [2:0]        id_idx,
    input  logic [DATA_W-1:0] count_q,
    input  logic [DATA_W-1:0] alarm_q,
    input  logic [DATA_W-1:0] load_q,
    input  logic              mask_q,
    input  logic              status_q,
    output logic [DATA_W-1:0] rdata
);

    // Source selection for the read data bus.
    always_comb begin
        case (rd_sel)
            RS_COUNT:  rdata = count_q;
            RS_ALARM:  rdata = alarm_q;
            RS_LOAD:   rdata = load_q;
            RS_CTRL:   rdata = DATA_W'(1);
            RS_MASK:   rdata = DATA_W'(mask_q);
            RS_RAW:    rdata = DATA_W'(status_q);
            RS_MASKED: rdata = DATA_W'(status_q & mask_q);
            RS_ID:     rdata = DATA_W'(id_byte(id_idx));
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/apb_rtc_alarm.sv
// Module: apb_rtc_alarm
// Top of the APB seconds counter with alarm. Connects the address decoder,
// prescaler, counter/alarm state and readback mux. No wait states; reads
// return data combinationally during the access. Assumes clk is the only
// clock and that CLK_HZ is the number of clk cycles per second.
module apb_rtc_alarm
    import rtc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [REG_AW-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              irq
);

    wr_strb_t          wr;
    rd_sel_e           rd_sel;
    logic [2:0]        id_idx;
    logic              tick;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] alarm_q;
    logic [DATA_W-1:0] load_q;
    logic              mask_q;
    logic              status_q;

    assign pready = 1'b1;
    assign irq    = status_q & mask_q;

    rtc_apb_decode u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr      (wr),
        .rd_sel  (rd_sel),
        .id_idx  (id_idx)
    );

    rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr.load),
        .tick    (tick)
    );

    rtc_counter_alarm u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr       (wr),
        .wdata    (pwdata),
        .count_q  (count_q),
        .alarm_q  (alarm_q),
        .load_q   (load_q),
        .mask_q   (mask_q),
        .status_q (status_q)
    );

    rtc_read_mux u_rmux (
        .rd_sel   (rd_sel),
        .id_idx   (id_idx),
        .count_q  (count_q),
        .alarm_q  (alarm_q),
        .load_q   (load_q),
        .mask_q   (mask_q),
        .status_q (status_q),
        .rdata    (prdata)
    );

endmodule

// File: rtl/rtc_alarm_checker.sv
// Module: rtc_alarm_checker
// Property checker for apb_rtc_alarm, attached by bind. Relates bus
// activity, the prescaler tick and the stored state across cycles.
module rtc_alarm_checker #(
    parameter int CLK_HZ = 50_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        irq,
    input logic        tick,
    input logic [31:0] count_q,
    input logic [31:0] alarm_q,
    input logic [31:0] load_q,
    input logic        mask_q,
    input logic        status_q
);

    logic bus_wr;
    logic bus_rd;
    assign bus_wr = psel && penable && pwrite;
    assign bus_rd = psel && !pwrite;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (count_q == 32'd0 && alarm_q == 32'd0 && load_q == 32'd0
                    && !mask_q && !status_q && !irq));

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(bus_wr && paddr == 12'h008)) |=> count_q == $past(count_q) + 32'd1);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(bus_wr && paddr == 12'h008)) |=> $stable(count_q));

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && paddr == 12'h008) |=> (count_q == $past(pwdata) && load_q == $past(pwdata)));

    generate
        if (CLK_HZ > 1) begin : g_restart
            assert_load_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && paddr == 12'h008) |=> !tick);
        end
    endgenerate

    assert_step_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !bus_wr && count_q + 32'd1 == alarm_q) |=> status_q);

    assert_load_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && paddr == 12'h008 && pwdata == alarm_q) |=> status_q);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && paddr == 12'h01C && !tick) |=> !status_q);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !(bus_wr && paddr == 12'h01C)) |=> status_q);

    assert_ctrl_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && paddr == 12'h00C) |-> prdata == 32'd1);

    assert_id_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && paddr == 12'hFFC) |-> prdata == 32'h0000_00B1);

    assert_clear_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && paddr == 12'h01C) |-> prdata == 32'd0);

endmodule

bind apb_rtc_alarm rtc_alarm_checker #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .irq      (irq),
    .tick     (tick),
    .count_q  (count_q),
    .alarm_q  (alarm_q),
    .load_q   (load_q),
    .mask_q   (mask_q),
    .status_q (status_q)
);

// File: tb/apb_rtc_alarm_tb.sv
// Bench for apb_rtc_alarm: a register vector table, then directed timing
// and corner-case tests. Inputs change on the falling edge.
module apb_rtc_alarm_tb;

    localparam int TB_HZ = 16;
    localparam int NVEC  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    apb_rtc_alarm #(.CLK_HZ(TB_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .irq(irq)
    );

    // Vector: {write, addr[11:0], data[31:0], expect[31:0], req[3:0]}
    localparam logic [80:0] VEC [NVEC] = '{
        {1'b0, 12'hFE0, 32'h0, 32'h31, 4'd9},
        {1'b0, 12'hFE4, 32'h0, 32'h10, 4'd9},
        {1'b0, 12'hFE8, 32'h0, 32'h14, 4'd9},
        {1'b0, 12'hFEC, 32'h0, 32'h00, 4'd9},
        {1'b0, 12'hFF0, 32'h0, 32'h0D, 4'd9},
        {1'b0, 12'hFF4, 32'h0, 32'hF0, 4'd9},
        {1'b0, 12'hFF8, 32'h0, 32'h05, 4'd9},
        {1'b0, 12'hFFC, 32'h0, 32'hB1, 4'd9},
        {1'b0, 12'h00C, 32'h0, 32'h1, 4'd8},
        {1'b1, 12'h00C, 32'h0, 32'h0, 4'd8},
        {1'b0, 12'h00C, 32'h0, 32'h1, 4'd8},
        {1'b1, 12'h010, 32'hFFFF_FFFE, 32'h0, 4'd6},
        {1'b0, 12'h010, 32'h0, 32'h0, 4'd6},
        {1'b1, 12'h010, 32'h3, 32'h0, 4'd6},
        {1'b0, 12'h010, 32'h0, 32'h1, 4'd6},
        {1'b1, 12'h010, 32'h0, 32'h0, 4'd6},
        {1'b1, 12'h008, 32'hCAFE_0000, 32'h0, 4'd3},
        {1'b0, 12'h008, 32'h0, 32'hCAFE_0000, 4'd3},
        {1'b1, 12'h004, 32'h1234_5678, 32'h0, 4'd4},
        {1'b0, 12'h004, 32'h0, 32'h1234_5678, 4'd4},
        {1'b0, 12'h01C, 32'h0, 32'h0, 4'd10},
        {1'b0, 12'h020, 32'h0, 32'h0, 4'd10},
        {1'b0, 12'h800, 32'h0, 32'h0, 4'd10},
        {1'b0, 12'h002, 32'h0, 32'h0, 4'd10},
        {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0, 4'd10},
        {1'b1, 12'h00A, 32'h0BAD_0BAD, 32'h0, 4'd10},
        {1'b1, 12'h014, 32'h1, 32'h0, 4'd10},
        {1'b0, 12'h014, 32'h0, 32'h0, 4'd10},
        {1'b1, 12'h018, 32'h1, 32'h0, 4'd10},
        {1'b0, 12'h018, 32'h0, 32'h0, 4'd10},
        {1'b0, 12'h008, 32'h0, 32'hCAFE_0000, 4'd10},
        {1'b0, 12'h004, 32'h0, 32'h1234_5678, 4'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write: setup at entry negedge, commit on the second rising edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Read: sample one cycle after entry.
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, v); check("R1 count", v, 32'h0);
        rd(12'h004, v); check("R1 alarm", v, 32'h0);
        rd(12'h008, v); check("R1 load", v, 32'h0);
        rd(12'h010, v); check("R1 mask", v, 32'h0);
        rd(12'h014, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][80]) begin
                wr(VEC[i][79:68], VEC[i][67:36]);
            end else begin
                rd(VEC[i][79:68], v);
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][35:4]);
            end
        end

        // R2/R3 increment period after a load
        wr(12'h004, 32'h9999);
        wr(12'h008, 32'd100);
        repeat (13) @(negedge clk);
        rd(12'h000, v); check("R3 no early step", v, 32'd100);
        rd(12'h000, v); check("R3 step after CLK_HZ", v, 32'd101);
        repeat (14) @(negedge clk);
        rd(12'h000, v); check("R2 second step", v, 32'd102);

        // R2/R4 wrap and alarm at zero
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h004, 32'h0);
        wr(12'h01C, 32'h0);
        rd(12'h014, v); check("R4 no early hit", v, 32'h0);
        repeat (12) @(negedge clk);
        rd(12'h000, v); check("R2 wrap to zero", v, 32'h0);
        rd(12'h014, v); check("R4 hit at wrap", v, 32'h1);
        check("R6 irq masked off", {31'b0, irq}, 32'h0);

        // R5 immediate hits from writes
        wr(12'h01C, 32'h0);
        wr(12'h008, 32'd500);
        wr(12'h004, 32'd500);
        rd(12'h014, v); check("R5 alarm write hit", v, 32'h1);
        wr(12'h01C, 32'h0);
        rd(12'h014, v); check("R7 clear", v, 32'h0);
        wr(12'h004, 32'd700);
        rd(12'h014, v); check("R5 no hit unequal", v, 32'h0);
        wr(12'h008, 32'd700);
        rd(12'h014, v); check("R5 load write hit", v, 32'h1);

        // R6 mask gating
        wr(12'h010, 32'h0);
        check("R6 irq mask0", {31'b0, irq}, 32'h0);
        rd(12'h018, v); check("R6 masked mask0", v, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        check("R6 irq mask1", {31'b0, irq}, 32'h1);
        rd(12'h018, v); check("R6 masked mask1", v, 32'h1);
        wr(12'h01C, 32'hA5A5_0000);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);
        rd(12'h014, v); check("R7 any data clears", v, 32'h0);

        // R7 hit and clear in the same cycle: set wins
        wr(12'h004, 32'h0000_1001);
        wr(12'h008, 32'h0000_1000);
        repeat (14) @(negedge clk);
        wr(12'h01C, 32'h0);
        rd(12'h014, v); check("R7 set wins", v, 32'h1);
        rd(12'h000, v); check("R2 count at collision", v, 32'h0000_1001);
        wr(12'h01C, 32'h0);
        rd(12'h014, v); check("R7 later clear", v, 32'h0);

        // R10 write to count ignored
        wr(12'h008, 32'h0000_2000);
        wr(12'h000, 32'h0000_00AB);
        rd(12'h000, v); check("R10 count write ignored", v, 32'h0000_2000);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(12'h008, v); check("R1 load after reset", v, 32'h0);
        rd(12'h004, v); check("R1 alarm after reset", v, 32'h0);
        rd(12'h010, v); check("R1 mask after reset", v, 32'h0);
        rd(12'h014, v); check("R1 status after reset", v, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule